// File: doc/BRIEF.md
# Voltage/Frequency Operating-Point Transition Sequencer

This block carries out performance-level changes for a single voltage/frequency domain. Software writes a target level, which is an index into a small table of operating points. Each table entry pairs a supply code for the voltage regulator with a select code for the clock divider or PLL. The sequencer then walks the domain to that level. It drives the regulator through a request/acknowledge pair and the clock select through a second request/acknowledge pair. It reports when the change is finished.

The order of the two steps depends on the direction of the change. A move to a faster level raises the supply first and waits for the regulator to confirm that the ramp is complete. Only then does it switch the clock and wait for lock. A move to a slower level switches the clock first and waits for lock. Only then does it lower the supply. As a result, the clock never runs faster than the present supply supports, provided the table is ordered so that a higher index means both more voltage and a faster clock.

Software writes are plain strobes with no back-pressure. At most one target is held pending. A newer write replaces an older pending one. The pending target starts as soon as the current transition completes.

Top module: `dvfs_seq`

## Requirements
- R1: In reset and after its release, `cur_level` equals `RESET_LEVEL`, `vreg_code` and `clk_sel` hold that table entry's codes, both requests are low, and `busy` and `done` are low.
- R2: With no write on `lvl_wr`, no request is raised, the codes stay unchanged, and `busy` stays low.
- R3: A target with a lower index than `cur_level` first drives the new `clk_sel` with `clk_req` high and waits for `clk_ack`. Only after that does it drive the new `vreg_code` and raise `vreg_req`.
- R4: A target with a higher index first drives the new `vreg_code` with `vreg_req` high and waits for `vreg_ack`. Only after that does it change `clk_sel` and raise `clk_req`.
- R5: In every cycle, the table index of the applied clock select is no higher than the table index of the applied supply code.
- R6: A request stays high until its acknowledge is seen, and then it drops one cycle later. While a request is held, its code does not change.
- R7: A target equal to `cur_level` gives one `done` pulse without raising any request or changing any code.
- R8: Writes made while a transition runs are held. Only the latest one is kept, and it starts after the running transition completes. A write in the same cycle as the pending target is taken is kept for the following transition.
- R9: `cur_level` changes only in the cycle in which `done` is high, and it then equals the target. At that point `vreg_code` and `clk_sel` equal the target entry's codes.
- R10: `vreg_req` and `clk_req` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lvl_wr | input | 1 | Software write strobe for a new target level |
| lvl_target | input | LVW | Target level index, sampled while `lvl_wr` is high |
| vreg_code | output | VW | Supply code presented to the regulator |
| vreg_req | output | 1 | Regulator request, held until `vreg_ack` |
| vreg_ack | input | 1 | Regulator reports that the ramp is complete; must be low while `vreg_req` is low |
| clk_sel | output | FW | Clock divider / PLL select code |
| clk_req | output | 1 | Clock change request, held until `clk_ack` |
| clk_ack | input | 1 | Clock reports lock on the new select; must be low while `clk_req` is low |
| busy | output | 1 | A transition is running or a target is pending |
| done | output | 1 | One-cycle pulse when a requested level has been reached |
| cur_level | output | LVW | Level the domain currently runs at |

## Verification
A software write and the hand-off of the pending target can land in the same cycle. In that cycle the latch must keep the new value rather than clear it. The bench provokes this by writing twice during a running transition and then writing again in the very cycle that `done` is observed. It judges the result by the number of `done` pulses, the order of the levels reached, and the final codes. Across random targets and random acknowledge delays, a per-cycle monitor checks the safe voltage/clock relation and confirms that each clock change or supply change waited for the other side's acknowledge.

// File: rtl/dvfs_seq_pkg.sv
package dvfs_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_VOLT_UP,
    ST_FREQ_UP,
    ST_FREQ_DN,
    ST_VOLT_DN,
    ST_FINISH
  } seq_st_e;
endpackage

// File: rtl/opp_lut.sv
module opp_lut #(
  parameter int N = 4,
  parameter int W = 8,
  parameter int LVW = $clog2(N),
  parameter logic [N*W-1:0] TABLE = '0
) (
  input  logic [LVW-1:0] idx,
  output logic [W-1:0]   code
);
  logic [W-1:0] entry [N];

  for (genvar g = 0; g < N; g++) begin : g_entry
    assign entry[g] = TABLE[g*W +: W];
  end

  assign code = entry[idx];
endmodule

// File: rtl/target_latch.sv
module target_latch #(
  parameter int LVW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr,
  input  logic [LVW-1:0] wr_lvl,
  input  logic           take,
  output logic           pend_vld,
  output logic [LVW-1:0] pend_lvl
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_vld <= 1'b0;
      pend_lvl <= '0;
    end else if (wr) begin
      pend_vld <= 1'b1;
      pend_lvl <= wr_lvl;
    end else if (take) begin
      pend_vld <= 1'b0;
    end
  end
endmodule

// File: rtl/step_engine.sv
module step_engine
  import dvfs_seq_pkg::*;
#(
  parameter int LVW = 2,
  parameter int RESET_LEVEL = 0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pend_vld,
  input  logic [LVW-1:0] pend_lvl,
  output logic           take,
  input  logic           vreg_ack,
  input  logic           clk_ack,
  output logic           vreg_req,
  output logic           clk_req,
  output logic [LVW-1:0] volt_lvl,
  output logic [LVW-1:0] freq_lvl,
  output logic [LVW-1:0] cur_lvl,
  output logic           done,
  output logic           idle
);
  localparam logic [LVW-1:0] RST_LVL = LVW'(RESET_LEVEL);

  seq_st_e        st;
  logic [LVW-1:0] tgt;

  assign idle = (st == ST_IDLE);
  assign take = idle && pend_vld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      tgt      <= RST_LVL;
      volt_lvl <= RST_LVL;
      freq_lvl <= RST_LVL;
      cur_lvl  <= RST_LVL;
      vreg_req <= 1'b0;
      clk_req  <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: if (pend_vld) begin
          tgt <= pend_lvl;
          if (pend_lvl == cur_lvl) begin
            done <= 1'b1;
          end else if (pend_lvl > cur_lvl) begin
            volt_lvl <= pend_lvl;
            vreg_req <= 1'b1;
            st       <= ST_VOLT_UP;
          end else begin
            freq_lvl <= pend_lvl;
            clk_req  <= 1'b1;
            st       <= ST_FREQ_DN;
          end
        end
        ST_VOLT_UP: if (vreg_ack) begin
          vreg_req <= 1'b0;
          freq_lvl <= tgt;
          clk_req  <= 1'b1;
          st       <= ST_FREQ_UP;
        end
        ST_FREQ_UP: if (clk_ack) begin
          clk_req <= 1'b0;
          st      <= ST_FINISH;
        end
        ST_FREQ_DN: if (clk_ack) begin
          clk_req  <= 1'b0;
          volt_lvl <= tgt;
          vreg_req <= 1'b1;
          st       <= ST_VOLT_DN;
        end
        ST_VOLT_DN: if (vreg_ack) begin
          vreg_req <= 1'b0;
          st       <= ST_FINISH;
        end
        ST_FINISH: begin
          cur_lvl <= tgt;
          done    <= 1'b1;
          st      <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dvfs_seq.sv
module dvfs_seq #(
  parameter int LEVELS = 4,
  parameter int VW = 8,
  parameter int FW = 4,
  parameter int LVW = $clog2(LEVELS),
  parameter int RESET_LEVEL = 0,
  parameter logic [LEVELS*VW-1:0] VCODE_TABLE = {8'h88, 8'h70, 8'h58, 8'h40},
  parameter logic [LEVELS*FW-1:0] FSEL_TABLE  = {4'h7, 4'h5, 4'h3, 4'h1}
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           lvl_wr,
  input  logic [LVW-1:0] lvl_target,
  output logic [VW-1:0]  vreg_code,
  output logic           vreg_req,
  input  logic           vreg_ack,
  output logic [FW-1:0]  clk_sel,
  output logic           clk_req,
  input  logic           clk_ack,
  output logic           busy,
  output logic           done,
  output logic [LVW-1:0] cur_level
);
  logic           pend_vld;
  logic [LVW-1:0] pend_lvl;
  logic           take;
  logic           idle;
  logic [LVW-1:0] volt_lvl;
  logic [LVW-1:0] freq_lvl;

  target_latch #(.LVW(LVW)) u_latch (
    .clk(clk), .rst_n(rst_n), .wr(lvl_wr), .wr_lvl(lvl_target),
    .take(take), .pend_vld(pend_vld), .pend_lvl(pend_lvl)
  );

  step_engine #(.LVW(LVW), .RESET_LEVEL(RESET_LEVEL)) u_engine (
    .clk(clk), .rst_n(rst_n), .pend_vld(pend_vld), .pend_lvl(pend_lvl),
    .take(take), .vreg_ack(vreg_ack), .clk_ack(clk_ack),
    .vreg_req(vreg_req), .clk_req(clk_req), .volt_lvl(volt_lvl),
    .freq_lvl(freq_lvl), .cur_lvl(cur_level), .done(done), .idle(idle)
  );

  opp_lut #(.N(LEVELS), .W(VW), .LVW(LVW), .TABLE(VCODE_TABLE)) u_vlut (
    .idx(volt_lvl), .code(vreg_code)
  );

  opp_lut #(.N(LEVELS), .W(FW), .LVW(LVW), .TABLE(FSEL_TABLE)) u_flut (
    .idx(freq_lvl), .code(clk_sel)
  );

  assign busy = !idle || pend_vld;
endmodule

// File: rtl/dvfs_seq_chk.sv
module dvfs_seq_chk #(
  parameter int LVW = 2,
  parameter int VW = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic [LVW-1:0] volt_lvl,
  input logic [LVW-1:0] freq_lvl,
  input logic           vreg_req,
  input logic           vreg_ack,
  input logic           clk_req,
  input logic           clk_ack,
  input logic [VW-1:0]  vreg_code,
  input logic           busy,
  input logic           done,
  input logic [LVW-1:0] cur_level
);
  // R5
  safe_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freq_lvl <= volt_lvl);

  // R10
  one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(vreg_req && clk_req));

  // R6
  vreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vreg_req && !vreg_ack) |=> vreg_req);

  // R6
  creq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_req && !clk_ack) |=> clk_req);

  // R6
  vcode_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vreg_req && $past(vreg_req)) |-> $stable(vreg_code));

  // R9
  cur_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_level != $past(cur_level)) |-> done);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!vreg_req && !clk_req));
endmodule

bind dvfs_seq dvfs_seq_chk #(.LVW(LVW), .VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .volt_lvl(volt_lvl), .freq_lvl(freq_lvl),
  .vreg_req(vreg_req), .vreg_ack(vreg_ack), .clk_req(clk_req),
  .clk_ack(clk_ack), .vreg_code(vreg_code), .busy(busy), .done(done),
  .cur_level(cur_level)
);

// File: tb/test_dvfs_seq.sv
`timescale 1ns/1ps
module test_dvfs_seq;
  localparam int LVW = 2;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lvl_wr = 1'b0;
  logic [LVW-1:0] lvl_target = '0;
  logic vreg_ack = 1'b0, clk_ack = 1'b0;
  logic [7:0] vreg_code;
  logic [3:0] clk_sel;
  logic vreg_req, clk_req, busy, done;
  logic [LVW-1:0] cur_level;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dvfs_seq i_dvfs_seq (
    .clk(clk), .rst_n(rst_n), .lvl_wr(lvl_wr), .lvl_target(lvl_target),
    .vreg_code(vreg_code), .vreg_req(vreg_req), .vreg_ack(vreg_ack),
    .clk_sel(clk_sel), .clk_req(clk_req), .clk_ack(clk_ack),
    .busy(busy), .done(done), .cur_level(cur_level)
  );

  // Expected table: index 0 slowest
  function automatic logic [7:0] exp_v(int i);
    case (i) 0: return 8'h40; 1: return 8'h58; 2: return 8'h70; default: return 8'h88; endcase
  endfunction
  function automatic logic [3:0] exp_f(int i);
    case (i) 0: return 4'h1; 1: return 4'h3; 2: return 4'h5; default: return 4'h7; endcase
  endfunction
  function automatic int v_idx(logic [7:0] c);
    for (int i = 0; i < 4; i++) if (exp_v(i) == c) return i;
    return 99;
  endfunction
  function automatic int f_idx(logic [3:0] c);
    for (int i = 0; i < 4; i++) if (exp_f(i) == c) return i;
    return 99;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Regulator and clock models with programmable delays
  int vdly = 2, cdly = 2, vcnt = 0, ccnt = 0;
  always_ff @(posedge clk) begin
    if (!vreg_req) begin vreg_ack <= 1'b0; vcnt <= 0; end
    else if (vcnt >= vdly) vreg_ack <= 1'b1;
    else vcnt <= vcnt + 1;
    if (!clk_req) begin clk_ack <= 1'b0; ccnt <= 0; end
    else if (ccnt >= cdly) clk_ack <= 1'b1;
    else ccnt <= ccnt + 1;
  end

  // Monitor, sampled on the falling edge
  int mv_dir = 0;
  bit seen_vreq, seen_creq, first_v, seen_vack, seen_cack;
  int ord_err = 0, safe_err = 0, cur_err = 0, quiet_err = 0;
  int fchg = 0, vchg = 0, n_done = 0;
  logic [7:0] pv; logic [3:0] pf; logic [LVW-1:0] pc;
  bit mon_on = 1'b0;

  always @(negedge clk) if (mon_on) begin
    if (f_idx(clk_sel) > v_idx(vreg_code)) safe_err++;
    if ((vreg_req && clk_req) || (!busy && (vreg_req || clk_req))) quiet_err++;
    if (vreg_req && !seen_vreq && !seen_creq) first_v = 1'b1;
    if (vreg_req) seen_vreq = 1'b1;
    if (clk_req) seen_creq = 1'b1;
    if (clk_sel != pf) begin
      fchg++;
      if (mv_dir > 0 && !seen_vack) ord_err++;
    end
    if (vreg_code != pv) begin
      vchg++;
      if (mv_dir < 0 && !seen_cack) ord_err++;
    end
    if (cur_level != pc && !done) cur_err++;
    if (done) n_done++;
    if (vreg_ack) seen_vack = 1'b1;
    if (clk_ack) seen_cack = 1'b1;
    pv = vreg_code; pf = clk_sel; pc = cur_level;
  end

  task automatic clear_mon(int dir);
    mv_dir = dir; seen_vreq = 0; seen_creq = 0; first_v = 0;
    seen_vack = 0; seen_cack = 0; fchg = 0; vchg = 0; n_done = 0; ord_err = 0;
  endtask

  task automatic write_lvl(int l);
    lvl_target = LVW'(l); lvl_wr = 1'b1;
    @(negedge clk); #1;
    lvl_wr = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 500; i++) begin
      if (done) return;
      @(negedge clk); #1;
    end
  endtask

  task automatic do_move(int tgt);
    int c0 = int'(cur_level);
    int dir = (tgt > c0) ? 1 : ((tgt < c0) ? -1 : 0);
    clear_mon(dir);
    write_lvl(tgt);
    wait_done();
    check("R9 cur_level at done", int'(cur_level), tgt);
    check("R9 vreg_code at done", int'(vreg_code), int'(exp_v(tgt)));
    check("R9 clk_sel at done", int'(clk_sel), int'(exp_f(tgt)));
    if (dir > 0) begin
      check("R4 supply request first", int'(first_v), 1);
      check("R4 clock waits for supply ack", ord_err, 0);
    end else if (dir < 0) begin
      check("R3 clock request first", int'(first_v && seen_vreq), 0);
      check("R3 supply waits for clock ack", ord_err, 0);
    end else begin
      check("R7 no request on equal target", int'(seen_vreq || seen_creq), 0);
      check("R7 codes unchanged", fchg + vchg, 0);
    end
    @(negedge clk); #1;
    check("R9 busy clears", int'(busy), 0);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    check("R1 reset cur_level", int'(cur_level), 0);
    check("R1 reset busy", int'(busy), 0);
    check("R1 reset requests", int'(vreg_req || clk_req || done), 0);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    check("R1 vreg_code after reset", int'(vreg_code), int'(exp_v(0)));
    check("R1 clk_sel after reset", int'(clk_sel), int'(exp_f(0)));
    pv = vreg_code; pf = clk_sel; pc = cur_level;
    mon_on = 1'b1;

    clear_mon(0);
    repeat (20) @(negedge clk); #1;
    check("R2 no request without write", int'(seen_vreq || seen_creq), 0);
    check("R2 codes stable without write", fchg + vchg, 0);

    do_move(3);
    do_move(0);
    do_move(0);
    vdly = 0; cdly = 0;
    do_move(2);
    do_move(1);
    do_move(1);

    // R8: stacked writes, with one in the cycle done is seen
    do_move(0);
    clear_mon(0);
    vdly = 3; cdly = 3;
    write_lvl(3);
    while (!vreg_req) begin @(negedge clk); #1; end
    write_lvl(1);
    write_lvl(1);
    wait_done();
    check("R8 first transition reaches level", int'(cur_level), 3);
    write_lvl(2);
    wait_done();
    check("R8 latest pending level runs next", int'(cur_level), 1);
    @(negedge clk); #1;
    wait_done();
    check("R8 same-cycle write kept", int'(cur_level), 2);
    repeat (10) @(negedge clk); #1;
    check("R8 number of done pulses", n_done, 3);

    for (int k = 0; k < 40; k++) begin
      vdly = int'($urandom % 6);
      cdly = int'($urandom % 6);
      do_move(int'($urandom % 4));
    end

    check("R5 clock index never above supply index", safe_err, 0);
    check("R10 single request at a time", quiet_err, 0);
    check("R9 cur_level changes only with done", cur_err, 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule